// File: doc/BRIEF.md
# Processor Reset Bus Sequencer

This block plays the power-on reset sequence of a processor that has 32-bit registers and a 16-bit data bus. It does this as a fixed script of bus microcycles. While reset is held it clears its registers and sets the supervisor flag. Once reset is released it runs a run of idle steps with no bus activity.

After the idle steps it performs six word reads, one after another:

- two words that form the initial stack pointer;
- two words that form the initial program counter;
- two instruction prefetches into a two-entry queue.

The stack-pointer and program-counter words come from an internal effective-address counter. The counter starts at zero and steps by two after each word. The prefetches read from the program counter, which steps by two after each one. When the last prefetch lands, the block raises a one-cycle completion pulse. It then sits still until the next reset.

The block runs on a clock at twice the bus rate, so one clock is one bus half-cycle. Every bus access has an address phase of 5 clocks followed by a data phase of 3 clocks. A slow memory can stretch the final data clock by holding ready low.

Top module: `reset_seq`

## Requirements
- R1: While reset is low the block drives no read strobe and done is low. The stack pointer, program counter and both queue entries read zero, and the supervisor output is 1.
- R2: After reset is released the block runs 12 idle steps of 8 clocks each with no read strobe. The first read strobe therefore appears in the 96th clock after release.
- R3: Each access holds the read strobe for a 5-clock address phase with word select low. It then holds the read strobe for a data phase with word select high, which lasts 3 clocks when ready stays high.
- R4: The six accesses use these addresses, in order: 0, 2, 4, 6, then P and P+2. Here P is the program counter assembled from the words at 4 and 6, truncated to the address width.
- R5: The stack pointer output equals the word read at address 0 in bits 31:16 and the word read at address 2 in bits 15:0. The more significant word is read first.
- R6: The program counter is loaded from the words at 4 (upper) and 6 (lower). It ends at P+4 after the two prefetches. The queue head then holds the word from P and the queue tail holds the word from P+2.
- R7: The program-space qualifier is high on every access of the sequence.
- R8: Data is taken only on the last data-phase clock while ready is high. While ready is low on that clock the phase is stretched and no register changes. Values on the data input during a stall have no effect.
- R9: Done is high for exactly one clock, 144 clocks after release when no stall occurs. After that there is no further read strobe, done stays low, and all outputs hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock (two clocks per bus cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | AW | Word address of the current access |
| bus_rd | output | 1 | Read strobe, high for both phases of an access |
| bus_wsel | output | 1 | Word select, high during the data phase |
| bus_prog | output | 1 | Program-space qualifier |
| bus_din | input | 16 | Read data, sampled on the last data clock |
| bus_ready | input | 1 | Memory ready; low stretches the data phase |
| ssp | output | 32 | Loaded supervisor stack pointer |
| pc | output | 32 | Program counter |
| pfq_head | output | 16 | Older prefetch queue entry |
| pfq_tail | output | 16 | Newer prefetch queue entry |
| supervisor | output | 1 | Supervisor flag, set by reset |
| done | output | 1 | One-cycle pulse when the sequence finishes |

## Verification
The assertions assume that `bus_ready` is a clean level that the memory changes only between clock edges. They also assume that the memory eventually raises ready during every stretched data phase, so no access stalls forever.

The bench drives ready and data on the falling edge. One run keeps ready high throughout. A second run lets ready pulse high one clock in three, so every data phase ends within a few clocks. While ready is low the bench puts a poison word on the data input. This way a capture taken at the wrong moment shows up in the loaded values.

// File: rtl/reset_seq.sv
`timescale 1ns/1ps
module reset_seq #(
  parameter int AW         = 24,
  parameter int IDLE_STEPS = 12,
  parameter int ADDR_CLKS  = 5,
  parameter int DATA_CLKS  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wsel,
  output logic          bus_prog,
  input  logic [15:0]   bus_din,
  input  logic          bus_ready,
  output logic [31:0]   ssp,
  output logic [31:0]   pc,
  output logic [15:0]   pfq_head,
  output logic [15:0]   pfq_tail,
  output logic          supervisor,
  output logic          done
);
  localparam int STEP_CLKS = ADDR_CLKS + DATA_CLKS;
  localparam int CW        = $clog2(STEP_CLKS);
  localparam int IW        = $clog2(IDLE_STEPS + 1);
  localparam int LAST_ACC  = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_DONE, ST_HALT} st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idle_n;
  logic [2:0]     acc;
  logic [AW-1:0]  ea;

  wire from_vec  = (acc < 3'd4);
  wire take_data = (state == ST_DATA) && (cnt == CW'(DATA_CLKS - 1)) && bus_ready;

  assign bus_rd   = (state == ST_ADDR) || (state == ST_DATA);
  assign bus_wsel = (state == ST_DATA);
  assign bus_prog = bus_rd && (acc <= 3'(LAST_ACC));
  assign bus_addr = from_vec ? ea : pc[AW-1:0];
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      idle_n     <= '0;
      acc        <= '0;
      ea         <= '0;
      ssp        <= '0;
      pc         <= '0;
      pfq_head   <= '0;
      pfq_tail   <= '0;
      supervisor <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cnt == CW'(STEP_CLKS - 1)) begin
            cnt <= '0;
            if (idle_n == IW'(IDLE_STEPS - 1)) state <= ST_ADDR;
            else idle_n <= idle_n + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: begin
          if (cnt == CW'(ADDR_CLKS - 1)) begin
            cnt   <= '0;
            state <= ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt != CW'(DATA_CLKS - 1)) begin
            cnt <= cnt + 1'b1;
          end else if (bus_ready) begin
            cnt <= '0;
            case (acc)
              3'd0: ssp[31:16] <= bus_din;
              3'd1: ssp[15:0]  <= bus_din;
              3'd2: pc[31:16]  <= bus_din;
              3'd3: pc[15:0]   <= bus_din;
              default: begin
                pfq_head <= pfq_tail;
                pfq_tail <= bus_din;
                pc       <= pc + 32'd2;
              end
            endcase
            if (from_vec) ea <= ea + AW'(2);
            if (acc == 3'(LAST_ACC)) state <= ST_DONE;
            else begin
              acc   <= acc + 1'b1;
              state <= ST_ADDR;
            end
          end
        end
        ST_DONE: state <= ST_HALT;
        default: state <= ST_HALT;
      endcase
    end
  end

  a_r3_wsel_inside_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wsel |-> bus_rd);

  a_r3_addr_phase_length: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wsel && !$past(bus_wsel)) |-> ($past(state) == ST_ADDR && $past(cnt) == CW'(ADDR_CLKS - 1)));

  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd) && !$past(take_data)) |-> $stable(bus_addr));

  a_r7_prog_space: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_prog);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wsel && !bus_ready) |=> ($stable(ssp) && $stable(pc) && $stable(pfq_head) && $stable(pfq_tail)));

  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take_data) && $past(acc) >= 3'd4) |-> (pc == $past(pc) + 32'd2));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !bus_rd));

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (!bus_rd && $stable(pc) && $stable(ssp)));

  a_r1_supervisor_set: assert property (@(posedge clk) disable iff (!rst_n)
    supervisor);
endmodule

// File: tb/sim_reset_seq.sv
`timescale 1ns/1ps
module sim_reset_seq;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_ready = 1'b1;
  logic          wait_mode = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wsel, bus_prog, supervisor, done;
  logic [15:0]   bus_din, pfq_head, pfq_tail;
  logic [31:0]   ssp, pc;

  int n_vec = 0;
  int n_bad = 0;
  logic [AW-1:0] expq[$];

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, ~a[7:0]};
  endfunction

  assign bus_din = bus_ready ? mem(bus_addr) : 16'hDEAD;

  reset_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wsel(bus_wsel), .bus_prog(bus_prog), .bus_din(bus_din),
    .bus_ready(bus_ready), .ssp(ssp), .pc(pc), .pfq_head(pfq_head),
    .pfq_tail(pfq_tail), .supervisor(supervisor), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected addresses and measures phase lengths
  logic prev_rd = 1'b0, prev_wsel = 1'b0;
  int addr_len = 0, data_len = 0, tick = 0;
  always @(negedge clk) begin
    tick++;
    bus_ready = wait_mode ? ((tick % 3) == 2) : 1'b1;
    if (!rst_n) begin
      prev_rd = 0; prev_wsel = 0; addr_len = 0; data_len = 0;
    end else begin
      if (bus_rd && !bus_wsel && (!prev_rd || prev_wsel)) begin
        if (expq.size() == 0) chk("R4 unexpected access", 32'(bus_addr), 32'hFFFFFFFF);
        else chk("R4 access address", 32'(bus_addr), 32'(expq.pop_front()));
        chk("R7 program qualifier", 32'(bus_prog), 32'd1);
      end
      if (bus_rd && !bus_wsel) addr_len++;
      if (bus_wsel && !prev_wsel) begin
        chk("R3 address phase clocks", 32'(addr_len), 32'd5);
        addr_len = 0;
      end
      if (bus_wsel) data_len++;
      if (!bus_wsel && prev_wsel) begin
        if (!wait_mode) chk("R3 data phase clocks", 32'(data_len), 32'd3);
        else chk("R8 stretched data phase", 32'(data_len >= 3), 32'd1);
        data_len = 0;
      end
      prev_rd = bus_rd; prev_wsel = bus_wsel;
    end
  end

  task automatic run(input logic stalls);
    logic [31:0] ssp_e, pc_e;
    int t, first_rd, done_t, seen;
    logic [31:0] pc_hold, ssp_hold;
    wait_mode = stalls;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ssp", ssp, 0);
    chk("R1 reset pc", pc, 0);
    chk("R1 reset queue", {pfq_head, pfq_tail}, 0);
    chk("R1 reset supervisor", 32'(supervisor), 1);
    chk("R1 reset strobe/done", {30'd0, bus_rd, done}, 0);
    ssp_e = {mem(0), mem(2)};
    pc_e  = {mem(4), mem(6)};
    expq.push_back(0); expq.push_back(2); expq.push_back(4); expq.push_back(6);
    expq.push_back(pc_e[AW-1:0]); expq.push_back(pc_e[AW-1:0] + AW'(2));
    rst_n = 1'b1;
    t = 0; first_rd = -1; done_t = -1;
    while (done_t < 0 && t < 4000) begin
      @(negedge clk);
      t++;
      if (bus_rd && first_rd < 0) first_rd = t;
      if (done) done_t = t;
    end
    chk("R2 first strobe clock", 32'(first_rd), 32'd96);
    if (!stalls) chk("R9 done clock", 32'(done_t), 32'd144);
    else chk("R8 done later under stalls", 32'(done_t > 144), 32'd1);
    chk("R5 stack pointer", ssp, ssp_e);
    chk("R6 program counter", pc, pc_e + 32'd4);
    chk("R6 queue head", 32'(pfq_head), 32'(mem(pc_e[AW-1:0])));
    chk("R6 queue tail", 32'(pfq_tail), 32'(mem(pc_e[AW-1:0] + AW'(2))));
    chk("R1 supervisor after sequence", 32'(supervisor), 1);
    chk("R4 all accesses seen", 32'(expq.size()), 0);
    pc_hold = pc; ssp_hold = ssp; seen = 0;
    repeat (16) begin
      @(negedge clk);
      if (bus_rd || done || pc !== pc_hold || ssp !== ssp_hold) seen++;
    end
    chk("R9 hold after done", 32'(seen), 0);
    expq.delete();
  endtask

  initial begin
    run(1'b0);
    run(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule